// File: doc/BRIEF.md
# Calibration and Fast-Lock Sequencer

This block times the settling sequence of an integer-N synthesizer after each write to its divider setting. It runs on the phase-detector clock. A divider write starts a VCO band-calibration window, and the charge pump is held in high impedance for that whole window. If boost mode is enabled, a window with the boosted charge-pump current code follows. The block then returns to the normal current code and goes idle.

The band search and the analog calibration sit outside this block. It only supplies the timing window and the pump controls. While a sequence runs, further divider writes are refused, and each refused write is recorded in a sticky flag that software clears.

Top module: `cal_fastlock_seq`

## Requirements
- R1: A `freq_wr_i` pulse sampled while idle starts calibration. On the next cycle both `cal_busy_o` and `seq_busy_o` are high.
- R2: While calibration is active, `pump_hiz_o` is high.
- R3: For a precision setting p from 0 to 10, calibration lasts exactly 11·2^p clock cycles.
- R4: A precision setting from 11 to 15 gives the same calibration length as 10, which is 11264 cycles.
- R5: When boost is enabled at the write, a boost window of exactly 3+4·t cycles follows calibration, where t is the 4-bit timer setting. During this window `cp_code_o` equals `cp_boost_i`, `seq_busy_o` is high, `cal_busy_o` is low, and `pump_hiz_o` follows `pump_hiz_i`.
- R6: Outside the calibration and boost windows, `cp_code_o` equals `cp_norm_i` and `seq_busy_o` is low. With boost disabled, the block returns to idle on the cycle right after the last calibration cycle.
- R7: `pump_hiz_i` high forces `pump_hiz_o` high in every phase.
- R8: A `freq_wr_i` pulse sampled while busy neither restarts nor lengthens the sequence. It sets `wr_reject_o` on the next cycle. A `status_rd_i` pulse clears the flag, but a refused write in the same cycle has priority and keeps it set.
- R9: The boost enable, the precision setting and the timer setting are captured at the accepted write. Changing them later has no effect on the running sequence. The two current codes are used as they stand in each cycle.
- R10: After reset the block is idle: `cp_code_o` equals `cp_norm_i`, and `cal_busy_o`, `seq_busy_o` and `wr_reject_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Phase-detector rate clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| freq_wr_i | input | 1 | Divider-register write strobe |
| status_rd_i | input | 1 | Status read strobe; clears the reject flag |
| fast_en_i | input | 1 | Boost window enable |
| cal_prec_i | input | 4 | Calibration precision exponent |
| fast_tmr_i | input | 4 | Boost window timer setting |
| cp_norm_i | input | 3 | Normal charge-pump current code |
| cp_boost_i | input | 3 | Boost charge-pump current code |
| pump_hiz_i | input | 1 | Static charge-pump high-impedance request |
| cp_code_o | output | 3 | Active charge-pump current code (current = step·(code+1)) |
| pump_hiz_o | output | 1 | Charge-pump high-impedance control |
| cal_busy_o | output | 1 | Calibration window active |
| seq_busy_o | output | 1 | Calibration or boost window active |
| wr_reject_o | output | 1 | Sticky flag for a refused write |

## Verification
The bench builds the block with its default parameters: a multiplier of 11, a precision ceiling of 10, and a boost base of 3 with a step of 4. At these values the longest calibration window, 11264 cycles, fits in one run, so the clamp of settings 11 to 15 is checked against the real ceiling rather than a scaled-down one. The short windows at precision 0 and 1 and at timer 0 make the cycle-exact edges of each phase easy to see. Refused writes during calibration and during boost, and setting changes in mid-sequence, are also covered.

// File: rtl/cfl_pkg.sv
package cfl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CAL   = 2'd1,
    PH_BOOST = 2'd2
  } cfl_phase_e;

  function automatic int unsigned cfl_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cfl_len_calc.sv
module cfl_len_calc #(
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned CAL_MULT  = 11,
  parameter int unsigned PREC_MAX  = 10,
  parameter int unsigned FAST_BASE = 3,
  parameter int unsigned FAST_STEP = 4,
  parameter int unsigned LEN_W     = 14
) (
  input  logic [SEL_W-1:0] prec_i,
  input  logic [SEL_W-1:0] tmr_i,
  output logic [LEN_W-1:0] cal_len_o,
  output logic [LEN_W-1:0] boost_len_o
);
  logic [SEL_W-1:0] prec_eff;

  // out-of-range precision falls back to the ceiling
  always_comb begin
    if (prec_i > SEL_W'(PREC_MAX)) prec_eff = SEL_W'(PREC_MAX);
    else                           prec_eff = prec_i;
  end

  assign cal_len_o   = LEN_W'(CAL_MULT) << prec_eff;
  assign boost_len_o = LEN_W'(FAST_BASE) + LEN_W'(FAST_STEP) * LEN_W'(tmr_i);

  always_comb begin
    assert_prec_clamped_R4: assert (prec_eff <= SEL_W'(PREC_MAX));
  end
endmodule

// File: rtl/cfl_timer.sv
module cfl_timer #(
  parameter int unsigned LEN_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             done_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (load_i)                    cnt_q <= load_val_i - LEN_W'(1);
    else if (tick_i && cnt_q != '0)     cnt_q <= cnt_q - LEN_W'(1);
  end

  assign done_o = (cnt_q == '0);

  assert_load_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (load_val_i != '0));
  assert_count_down_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && !done_o) |=> (cnt_q == $past(cnt_q) - LEN_W'(1)));
endmodule

// File: rtl/cfl_ctrl.sv
module cfl_ctrl
  import cfl_pkg::*;
#(
  parameter int unsigned LEN_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             freq_wr_i,
  input  logic             status_rd_i,
  input  logic             fast_en_i,
  input  logic [LEN_W-1:0] cal_len_i,
  input  logic [LEN_W-1:0] boost_len_i,
  input  logic             tmr_done_i,
  output logic             tmr_load_o,
  output logic [LEN_W-1:0] tmr_val_o,
  output logic             tmr_tick_o,
  output cfl_phase_e       phase_o,
  output logic             reject_o
);
  cfl_phase_e       phase_q, phase_d;
  logic             fast_q;
  logic [LEN_W-1:0] boost_q;
  logic             reject_q;
  logic             accept;

  assign accept = freq_wr_i && (phase_q == PH_IDLE);

  always_comb begin
    phase_d    = phase_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = cal_len_i;
    unique case (phase_q)
      PH_IDLE: if (freq_wr_i) begin
        phase_d    = PH_CAL;
        tmr_load_o = 1'b1;
      end
      PH_CAL: if (tmr_done_i) begin
        if (fast_q) begin
          phase_d    = PH_BOOST;
          tmr_load_o = 1'b1;
          tmr_val_o  = boost_q;
        end else begin
          phase_d = PH_IDLE;
        end
      end
      PH_BOOST: if (tmr_done_i) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      fast_q   <= 1'b0;
      boost_q  <= '0;
      reject_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (accept) begin
        fast_q  <= fast_en_i;
        boost_q <= boost_len_i;
      end
      if (freq_wr_i && !accept) reject_q <= 1'b1;
      else if (status_rd_i)     reject_q <= 1'b0;
    end
  end

  assign tmr_tick_o = (phase_q != PH_IDLE);
  assign phase_o    = phase_q;
  assign reject_o   = reject_q;

  assert_boost_after_cal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_BOOST) |-> ($past(phase_q) == PH_CAL || $past(phase_q) == PH_BOOST));
  assert_busy_write_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freq_wr_i && phase_q == PH_BOOST && !tmr_done_i) |=> (phase_q == PH_BOOST));
endmodule

// File: rtl/cal_fastlock_seq.sv
module cal_fastlock_seq
  import cfl_pkg::*;
#(
  parameter int unsigned CODE_W    = 3,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned CAL_MULT  = 11,
  parameter int unsigned PREC_MAX  = 10,
  parameter int unsigned FAST_BASE = 3,
  parameter int unsigned FAST_STEP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              freq_wr_i,
  input  logic              status_rd_i,
  input  logic              fast_en_i,
  input  logic [SEL_W-1:0]  cal_prec_i,
  input  logic [SEL_W-1:0]  fast_tmr_i,
  input  logic [CODE_W-1:0] cp_norm_i,
  input  logic [CODE_W-1:0] cp_boost_i,
  input  logic              pump_hiz_i,
  output logic [CODE_W-1:0] cp_code_o,
  output logic              pump_hiz_o,
  output logic              cal_busy_o,
  output logic              seq_busy_o,
  output logic              wr_reject_o
);
  localparam int unsigned CAL_MAX  = CAL_MULT << PREC_MAX;
  localparam int unsigned FAST_MAX = FAST_BASE + FAST_STEP * ((1 << SEL_W) - 1);
  localparam int unsigned LEN_W    = $clog2(cfl_max(CAL_MAX, FAST_MAX) + 1);

  logic [LEN_W-1:0] cal_len, boost_len, tmr_val;
  logic             tmr_load, tmr_tick, tmr_done;
  cfl_phase_e       phase;

  cfl_len_calc #(
    .SEL_W(SEL_W), .CAL_MULT(CAL_MULT), .PREC_MAX(PREC_MAX),
    .FAST_BASE(FAST_BASE), .FAST_STEP(FAST_STEP), .LEN_W(LEN_W)
  ) i_len (
    .prec_i     (cal_prec_i),
    .tmr_i      (fast_tmr_i),
    .cal_len_o  (cal_len),
    .boost_len_o(boost_len)
  );

  cfl_ctrl #(.LEN_W(LEN_W)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .freq_wr_i  (freq_wr_i),
    .status_rd_i(status_rd_i),
    .fast_en_i  (fast_en_i),
    .cal_len_i  (cal_len),
    .boost_len_i(boost_len),
    .tmr_done_i (tmr_done),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .tmr_tick_o (tmr_tick),
    .phase_o    (phase),
    .reject_o   (wr_reject_o)
  );

  cfl_timer #(.LEN_W(LEN_W)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .tick_i    (tmr_tick),
    .done_o    (tmr_done)
  );

  assign cal_busy_o = (phase == PH_CAL);
  assign seq_busy_o = (phase != PH_IDLE);
  assign pump_hiz_o = pump_hiz_i || (phase == PH_CAL);
  assign cp_code_o  = (phase == PH_BOOST) ? cp_boost_i : cp_norm_i;

  assert_start_cal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freq_wr_i && !seq_busy_o) |=> (cal_busy_o && seq_busy_o));
  assert_cal_hiz_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_busy_o |-> pump_hiz_o);
  assert_force_hiz_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pump_hiz_i |-> pump_hiz_o);
  assert_reject_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freq_wr_i && seq_busy_o) |=> wr_reject_o);
  assert_idle_norm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seq_busy_o |-> (cp_code_o == cp_norm_i && !cal_busy_o));
endmodule

// File: tb/test_cal_fastlock_seq.sv
module test_cal_fastlock_seq;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       freq_wr_i = 0, status_rd_i = 0, fast_en_i = 0, pump_hiz_i = 0;
  logic [3:0] cal_prec_i = 0, fast_tmr_i = 0;
  logic [2:0] cp_norm_i = 3'd2, cp_boost_i = 3'd6;
  logic [2:0] cp_code_o;
  logic       pump_hiz_o, cal_busy_o, seq_busy_o, wr_reject_o;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  cal_fastlock_seq i_cal_fastlock_seq (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // behavioural reference: phase 0 idle, 1 cal, 2 boost; m_left = cycles remaining
  int m_phase = 0, m_left = 0, m_flen = 0;
  bit m_fast = 0, m_rej = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_phase = 0; m_left = 0; m_rej = 0; m_fast = 0;
    end else begin
      if (freq_wr_i && m_phase != 0) m_rej = 1;
      else if (status_rd_i)          m_rej = 0;
      case (m_phase)
        0: if (freq_wr_i) begin
          m_phase = 1;
          m_left  = 11 * (2 ** ((cal_prec_i > 10) ? 10 : cal_prec_i));
          m_fast  = fast_en_i;
          m_flen  = 3 + 4 * fast_tmr_i;
        end
        1: begin
          m_left--;
          if (m_left == 0) begin
            if (m_fast) begin m_phase = 2; m_left = m_flen; end
            else m_phase = 0;
          end
        end
        default: begin
          m_left--;
          if (m_left == 0) m_phase = 0;
        end
      endcase
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk_i) if (rst_ni) begin
    chk(cal_busy_o, m_phase == 1, "R1/R3 cal_busy");
    chk(seq_busy_o, m_phase != 0, "R6 seq_busy");
    chk(pump_hiz_o, pump_hiz_i || m_phase == 1, "R2/R7 pump_hiz");
    chk(cp_code_o, (m_phase == 2) ? cp_boost_i : cp_norm_i, "R5/R9 cp_code");
    chk(wr_reject_o, m_rej, "R8 wr_reject");
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <190000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // start a sequence, optionally scramble captured settings, measure both windows
  task automatic run_seq(input int prec, input bit fe, input int tmr, input bit scramble,
                         input int exp_cal, input int exp_boost, input string tag);
    int nc = 0, nb = 0;
    @(negedge clk_i);
    cal_prec_i = 4'(prec); fast_en_i = fe; fast_tmr_i = 4'(tmr); freq_wr_i = 1;
    @(negedge clk_i);
    freq_wr_i = 0;
    if (scramble) begin cal_prec_i = 4'd5; fast_en_i = ~fe; fast_tmr_i = 4'd9; end
    while (cal_busy_o) begin nc++; @(negedge clk_i); end
    while (seq_busy_o) begin
      nb++;
      if (nb == 2) cp_boost_i = 3'd5;  // live code change
      @(negedge clk_i);
    end
    chk(nc, exp_cal, {tag, " cal length"});
    chk(nb, exp_boost, {tag, " boost length"});
    cp_boost_i = 3'd6;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(cal_busy_o, 0, "R10 reset cal_busy");
    chk(seq_busy_o, 0, "R10 reset seq_busy");
    chk(wr_reject_o, 0, "R10 reset reject");
    chk(cp_code_o, cp_norm_i, "R10 reset code");
    rst_ni = 1;
    @(negedge clk_i);

    run_seq(0, 0, 0, 0, 11, 0, "R3 R6 p0 no-boost");
    run_seq(2, 1, 0, 0, 44, 3, "R3 R5 p2 t0");
    run_seq(1, 1, 15, 0, 22, 63, "R5 p1 t15");
    run_seq(1, 1, 2, 1, 22, 11, "R9 scrambled");
    run_seq(3, 0, 7, 1, 88, 0, "R9 scrambled no-boost");
    run_seq(15, 1, 1, 0, 11264, 7, "R4 clamp p15");
    run_seq(10, 0, 0, 0, 11264, 0, "R3 p10");

    // refused write during calibration and during boost
    @(negedge clk_i);
    cal_prec_i = 0; fast_en_i = 1; fast_tmr_i = 1; freq_wr_i = 1;
    @(negedge clk_i); freq_wr_i = 0;
    repeat (4) @(negedge clk_i);
    freq_wr_i = 1; @(negedge clk_i); freq_wr_i = 0;
    chk(wr_reject_o, 1, "R8 reject in cal");
    repeat (8) @(negedge clk_i);
    chk(seq_busy_o && !cal_busy_o, 1, "R8 boost reached unchanged");
    status_rd_i = 1; @(negedge clk_i); status_rd_i = 0;
    chk(wr_reject_o, 0, "R8 status read clears");
    freq_wr_i = 1; status_rd_i = 1; @(negedge clk_i); freq_wr_i = 0; status_rd_i = 0;
    chk(wr_reject_o, 1, "R8 reject wins over read");
    while (seq_busy_o) @(negedge clk_i);
    chk(wr_reject_o, 1, "R8 sticky after idle");

    // forced high impedance in all phases
    pump_hiz_i = 1;
    run_seq(0, 1, 0, 0, 11, 3, "R7 forced hiz");
    chk(pump_hiz_o, 1, "R7 idle forced hiz");
    pump_hiz_i = 0;

    // reset in mid-sequence
    @(negedge clk_i); freq_wr_i = 1; @(negedge clk_i); freq_wr_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 0; @(negedge clk_i);
    chk(seq_busy_o, 0, "R10 reset mid-run busy");
    chk(wr_reject_o, 0, "R10 reset clears reject");
    rst_ni = 1;
    repeat (2) @(negedge clk_i);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule